// File: doc/BRIEF.md
# Parallel Port Bridge Mode Detector

This block sits on the device side of a PC-style parallel port. It watches the eight data lines and four host control lines: strobe, autofeed, init and select-in. It decides whether the port is working as a plain printer connection or as a bridge into a peripheral controller. After reset the block is in pass-through. In pass-through every host line reaches the downstream printer connector through combinational logic only.

The host enters bridge mode with an unlock sequence. The data lines must hold the magic byte 0xF7 with select-in negated. Init is then asserted. Select-in is then pulsed high and low while init stays asserted. Once in bridge mode, the host reads a fixed two-byte signature to confirm that the adapter is present. It may also write a small configuration register that holds a one-direction port flag, a delay field and a soft-reset bit. The host negates init to return to pass-through, so bridge mode lasts only for the length of one command.

All control and data inputs pass through a two-flop synchroniser in the adapter clock domain, and edges are detected there, before the sequence checker sees them. All input lines use active-high logical levels: 1 means asserted.

Top module: `pp_mode_detect`

## Requirements
- R1: After reset, bridge_active is 0, rd_drive is 0, cfg_unidir is 0 and cfg_delay is 0.
- R2: While bridge_active is 0, prn_data, prn_strobe, prn_autofeed, prn_init and prn_selin equal the matching host inputs in the same cycle.
- R3: Bridge mode is entered when all of the following happen in order, with data held at 0xF7 throughout: init rises while select-in is negated, then select-in rises, then select-in falls, with init asserted from its rise to the select-in fall.
- R4: If the data lines differ from 0xF7 at any step of the sequence, bridge mode is not entered.
- R5: A select-in pulse while init is negated does not start or advance the sequence. A later init rise without a fresh select-in pulse does not enter bridge mode.
- R6: If init is negated before the select-in fall that completes the sequence, bridge mode is not entered.
- R7: A read is select-in asserted with strobe negated, in bridge mode. During a read rd_drive is 1. The falling edge of select-in ends the read. Successive reads return 0xE8, then 0xFF, then 0x00 for every later read. Outside bridge mode rd_drive is 0.
- R8: Negating init in bridge mode returns the block to pass-through. A later re-entry restarts the signature at 0xE8.
- R9: While bridge_active is 1, prn_strobe and prn_autofeed are held at 0.
- R10: A configuration write is a select-in rise while strobe is asserted, in bridge mode, with data bit 6 = 1 and bit 0 = 0. It loads cfg_unidir from data bit 1 and cfg_delay from data bits 4:2. It does not advance the signature, provided select-in falls before strobe.
- R11: A configuration write with data bit 6 = 1 and bit 0 = 1 clears bridge_active, cfg_unidir, cfg_delay and the signature count in one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Adapter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 8 | Host data lines |
| host_strobe | input | 1 | Host strobe, 1 = asserted |
| host_autofeed | input | 1 | Host autofeed, 1 = asserted |
| host_init | input | 1 | Host init, 1 = asserted |
| host_selin | input | 1 | Host select-in, 1 = asserted |
| prn_data | output | 8 | Data to printer connector |
| prn_strobe | output | 1 | Strobe to printer connector |
| prn_autofeed | output | 1 | Autofeed to printer connector |
| prn_init | output | 1 | Init to printer connector |
| prn_selin | output | 1 | Select-in to printer connector |
| bridge_active | output | 1 | 1 while in bridge mode |
| rd_drive | output | 1 | 1 while rd_data should drive the host |
| rd_data | output | 8 | Signature readback byte |
| cfg_unidir | output | 1 | One-direction port flag |
| cfg_delay | output | DLY_W | Delay field |

## Verification
The bench attacks the unlock sequence from several sides: a wrong magic byte, a select-in pulse without init, and init dropped between the select-in edges. A checker that is too loose would report bridge mode after any of these. It also checks that the signature restarts at 0xE8 after both an exit and a soft reset. A counter that is never cleared would return 0xFF or 0x00 first. A configuration write placed between the two reads must not use up a signature byte, which catches a design that counts every select-in fall as a read. Strobe blocking in bridge mode and exact forwarding in pass-through are sampled at the printer pins.

// File: rtl/pp_mode_pkg.sv
package pp_mode_pkg;
  localparam logic [7:0] UNLOCK_BYTE = 8'hF7;
  localparam logic [7:0] SIG_FIRST   = 8'hE8;
  localparam logic [7:0] SIG_SECOND  = 8'hFF;
  localparam logic [7:0] SIG_TAIL    = 8'h00;
  localparam int CFG_SEL_BIT   = 6;
  localparam int CFG_RST_BIT   = 0;
  localparam int CFG_UNI_BIT   = 1;
  localparam int CFG_DLY_LSB   = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_SELHI  = 2'd2,
    ST_BRIDGE = 2'd3
  } mode_state_t;

  function automatic logic [7:0] sig_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    sig_byte = SIG_FIRST;
      2'd1:    sig_byte = SIG_SECOND;
      default: sig_byte = SIG_TAIL;
    endcase
  endfunction
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pp_edge.sv
module pp_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = d[i] & ~prev[i];
    assign fall[i] = ~d[i] & prev[i];
  end
endmodule

// File: rtl/pp_entry_fsm.sv
module pp_entry_fsm
  import pp_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_s,
  input  logic selin_s,
  input  logic init_rise,
  input  logic selin_rise,
  input  logic selin_fall,
  input  logic data_match,
  input  logic soft_rst,
  output logic bridge
);
  mode_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:
        if (init_rise && data_match && !selin_s) state_nx = ST_ARMED;
      ST_ARMED:
        if (!init_s || !data_match) state_nx = ST_IDLE;
        else if (selin_rise)        state_nx = ST_SELHI;
      ST_SELHI:
        if (!init_s || !data_match) state_nx = ST_IDLE;
        else if (selin_fall)        state_nx = ST_BRIDGE;
      ST_BRIDGE:
        if (!init_s) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
    if (soft_rst) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign bridge = (state == ST_BRIDGE);
endmodule

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bridge,
  input  logic             wr_ev,
  input  logic             wr_sel,
  input  logic             wr_rst,
  input  logic             wr_uni,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic             rd_done,
  output logic             soft_rst,
  output logic [1:0]       rd_idx,
  output logic             cfg_unidir,
  output logic [DLY_W-1:0] cfg_delay
);
  localparam logic [1:0] IDX_LAST = 2'd2;

  logic cfg_load;

  assign soft_rst = wr_ev & wr_sel & wr_rst;
  assign cfg_load = wr_ev & wr_sel & ~wr_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_unidir <= 1'b0;
      cfg_delay  <= '0;
    end else if (soft_rst) begin
      cfg_unidir <= 1'b0;
      cfg_delay  <= '0;
    end else if (cfg_load) begin
      cfg_unidir <= wr_uni;
      cfg_delay  <= wr_dly;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             rd_idx <= '0;
    else if (soft_rst || !bridge)           rd_idx <= '0;
    else if (rd_done && rd_idx != IDX_LAST) rd_idx <= rd_idx + 2'd1;
  end
endmodule

// File: rtl/pp_mode_detect.sv
module pp_mode_detect
  import pp_mode_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       host_data,
  input  logic             host_strobe,
  input  logic             host_autofeed,
  input  logic             host_init,
  input  logic             host_selin,
  output logic [7:0]       prn_data,
  output logic             prn_strobe,
  output logic             prn_autofeed,
  output logic             prn_init,
  output logic             prn_selin,
  output logic             bridge_active,
  output logic             rd_drive,
  output logic [7:0]       rd_data,
  output logic             cfg_unidir,
  output logic [DLY_W-1:0] cfg_delay
);
  localparam int CTL_W = 3;

  logic [CTL_W-1:0] ctl_s;
  logic [7:0]       data_s;
  logic [1:0]       rise2, fall2;
  logic             stb_s, init_s, selin_s;
  logic             ev_init_rise, ev_selin_rise, ev_selin_fall;
  logic             ev_wr, ev_rd_done, ev_soft_rst, data_match;
  logic [1:0]       rd_idx;

  pp_sync #(.W(CTL_W)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_selin, host_init, host_strobe}), .q(ctl_s)
  );
  pp_sync #(.W(8)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .d(host_data), .q(data_s)
  );

  assign stb_s   = ctl_s[0];
  assign init_s  = ctl_s[1];
  assign selin_s = ctl_s[2];

  pp_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .d({selin_s, init_s}),
    .rise(rise2), .fall(fall2)
  );

  assign ev_init_rise  = rise2[0];
  assign ev_selin_rise = rise2[1];
  assign ev_selin_fall = fall2[1];
  assign data_match    = (data_s == UNLOCK_BYTE);
  assign ev_wr         = bridge_active & ev_selin_rise & stb_s;
  assign ev_rd_done    = bridge_active & ev_selin_fall & ~stb_s;

  pp_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .init_s(init_s), .selin_s(selin_s),
    .init_rise(ev_init_rise), .selin_rise(ev_selin_rise),
    .selin_fall(ev_selin_fall), .data_match(data_match),
    .soft_rst(ev_soft_rst), .bridge(bridge_active)
  );

  pp_cfg_regs #(.DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bridge(bridge_active),
    .wr_ev(ev_wr),
    .wr_sel(data_s[CFG_SEL_BIT]),
    .wr_rst(data_s[CFG_RST_BIT]),
    .wr_uni(data_s[CFG_UNI_BIT]),
    .wr_dly(data_s[CFG_DLY_LSB +: DLY_W]),
    .rd_done(ev_rd_done),
    .soft_rst(ev_soft_rst), .rd_idx(rd_idx),
    .cfg_unidir(cfg_unidir), .cfg_delay(cfg_delay)
  );

  assign rd_data  = sig_byte(rd_idx);
  assign rd_drive = bridge_active & selin_s & ~stb_s;

  assign prn_data     = host_data;
  assign prn_init     = host_init;
  assign prn_selin    = host_selin;
  assign prn_strobe   = bridge_active ? 1'b0 : host_strobe;
  assign prn_autofeed = bridge_active ? 1'b0 : host_autofeed;
endmodule

// File: rtl/pp_mode_detect_chk.sv
module pp_mode_detect_chk #(
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bridge_active,
  input logic             init_s,
  input logic             ev_selin_fall,
  input logic             ev_soft_rst,
  input logic             ev_wr,
  input logic [7:0]       data_s,
  input logic [7:0]       rd_data,
  input logic             cfg_unidir,
  input logic [DLY_W-1:0] cfg_delay
);
  // R3
  entry_after_sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_active) |-> $past(ev_selin_fall) && init_s);

  // R6
  no_entry_without_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_s && !bridge_active) |=> !bridge_active);

  // R8
  exit_on_init_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_active && !init_s) |=> !bridge_active);

  // R7
  sig_starts_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bridge_active) |-> rd_data == 8'hE8);

  // R11
  soft_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> !bridge_active && !cfg_unidir && cfg_delay == '0);

  // R10
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && data_s[6] && !data_s[0]) |=>
      cfg_unidir == $past(data_s[1]) && cfg_delay == $past(data_s[2 +: DLY_W]));
endmodule

bind pp_mode_detect pp_mode_detect_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bridge_active(bridge_active),
  .init_s(init_s), .ev_selin_fall(ev_selin_fall),
  .ev_soft_rst(ev_soft_rst), .ev_wr(ev_wr), .data_s(data_s),
  .rd_data(rd_data), .cfg_unidir(cfg_unidir), .cfg_delay(cfg_delay)
);

// File: tb/pp_mode_detect_test.sv
module pp_mode_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       host_strobe = 1'b0, host_autofeed = 1'b0;
  logic       host_init = 1'b0, host_selin = 1'b0;
  logic [7:0] prn_data, rd_data;
  logic       prn_strobe, prn_autofeed, prn_init, prn_selin;
  logic       bridge_active, rd_drive, cfg_unidir;
  logic [2:0] cfg_delay;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pp_mode_detect uut (
    .clk(clk), .rst_n(rst_n), .host_data(host_data),
    .host_strobe(host_strobe), .host_autofeed(host_autofeed),
    .host_init(host_init), .host_selin(host_selin),
    .prn_data(prn_data), .prn_strobe(prn_strobe),
    .prn_autofeed(prn_autofeed), .prn_init(prn_init),
    .prn_selin(prn_selin), .bridge_active(bridge_active),
    .rd_drive(rd_drive), .rd_data(rd_data),
    .cfg_unidir(cfg_unidir), .cfg_delay(cfg_delay)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic idle_lines();
    host_data = 8'h00; host_strobe = 0; host_autofeed = 0;
    host_init = 0; host_selin = 0;
    settle();
  endtask

  task automatic enter_seq();
    host_data = 8'hF7; host_selin = 0; settle();
    host_init = 1; settle();
    host_selin = 1; settle();
    host_selin = 0; settle();
  endtask

  task automatic do_read(output logic [7:0] v, output logic drv);
    host_strobe = 0; host_selin = 1; settle();
    v = rd_data; drv = rd_drive;
    host_selin = 0; settle();
  endtask

  task automatic do_write(input logic [7:0] b);
    host_data = b; settle();
    host_strobe = 1; settle();
    host_selin = 1; settle();
    host_selin = 0; settle();
    host_strobe = 0; settle();
  endtask

  task automatic t_reset();
    chk("R1 bridge", bridge_active, 0);
    chk("R1 rd_drive", rd_drive, 0);
    chk("R1 unidir", cfg_unidir, 0);
    chk("R1 delay", cfg_delay, 0);
  endtask

  task automatic t_passthru();
    host_data = 8'hA5; host_strobe = 1; host_autofeed = 0; host_init = 1; host_selin = 0;
    #1;
    chk("R2 pattern1", {prn_data, prn_strobe, prn_autofeed, prn_init, prn_selin}, {8'hA5, 4'b1010});
    host_data = 8'h3C; host_strobe = 0; host_autofeed = 1; host_init = 0; host_selin = 1;
    #1;
    chk("R2 pattern2", {prn_data, prn_strobe, prn_autofeed, prn_init, prn_selin}, {8'h3C, 4'b0101});
    host_selin = 0; settle();
    chk("R7 no drive outside bridge", rd_drive, 0);
    idle_lines();
  endtask

  task automatic t_bad_byte();
    host_data = 8'hF6; settle();
    host_init = 1; settle();
    host_selin = 1; settle();
    host_selin = 0; settle();
    chk("R4 wrong byte at start", bridge_active, 0);
    idle_lines();
    host_data = 8'hF7; settle();
    host_init = 1; settle();
    host_selin = 1; settle();
    host_data = 8'h77; settle();
    host_data = 8'hF7; host_selin = 0; settle();
    chk("R4 byte changed mid-sequence", bridge_active, 0);
    idle_lines();
  endtask

  task automatic t_no_init();
    host_data = 8'hF7; settle();
    host_selin = 1; settle();
    host_selin = 0; settle();
    chk("R5 selin pulse without init", bridge_active, 0);
    host_init = 1; settle();
    chk("R5 init rise after stray pulse", bridge_active, 0);
    idle_lines();
  endtask

  task automatic t_init_drop();
    host_data = 8'hF7; settle();
    host_init = 1; settle();
    host_selin = 1; settle();
    host_init = 0; settle();
    host_selin = 0; settle();
    chk("R6 init dropped before selin fall", bridge_active, 0);
    idle_lines();
  endtask

  task automatic t_enter_and_sig();
    logic [7:0] v; logic d;
    enter_seq();
    chk("R3 entered", bridge_active, 1);
    do_read(v, d);
    chk("R7 first sig", v, 8'hE8);
    chk("R7 drive during read", d, 1);
    host_strobe = 1; host_autofeed = 1; #1;
    chk("R9 strobe blocked", {prn_strobe, prn_autofeed}, 2'b00);
    host_strobe = 0; host_autofeed = 0; settle();
    do_write(8'h56);
    chk("R10 unidir", cfg_unidir, 1);
    chk("R10 delay", cfg_delay, 5);
    do_read(v, d);
    chk("R10 R7 second sig after write", v, 8'hFF);
    do_read(v, d);
    chk("R7 tail byte", v, 8'h00);
    do_read(v, d);
    chk("R7 tail byte repeat", v, 8'h00);
  endtask

  task automatic t_exit_reenter();
    logic [7:0] v; logic d;
    host_init = 0; settle();
    chk("R8 exit on init drop", bridge_active, 0);
    host_strobe = 1; #1;
    chk("R8 R2 strobe forwarded again", prn_strobe, 1);
    host_strobe = 0;
    idle_lines();
    enter_seq();
    chk("R8 re-entered", bridge_active, 1);
    do_read(v, d);
    chk("R8 signature restarts", v, 8'hE8);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v; logic d;
    do_write(8'h4E);
    chk("R10 second load delay", cfg_delay, 3);
    do_write(8'h41);
    chk("R11 bridge cleared", bridge_active, 0);
    chk("R11 cfg cleared", {cfg_unidir, cfg_delay}, 4'h0);
    idle_lines();
    enter_seq();
    do_read(v, d);
    chk("R11 counter cleared", v, 8'hE8);
    idle_lines();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_passthru();
    t_bad_byte();
    t_no_init();
    t_init_drop();
    t_enter_and_sig();
    t_exit_reenter();
    t_soft_reset();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end
endmodule